// File: doc/BRIEF.md
# Load-Use Stall Detector

This block sits beside the decode stage of an in-order five-stage pipeline. Each cycle it compares the destination register of the instruction now in execute against the two source register fields of the instruction now in decode. When the execute-stage instruction is a memory read and its destination matches either decode source, the read data will not exist until the end of the memory stage. That is too late for forwarding into the next execute cycle, so the front end must wait one cycle.

During that wait the block holds the program counter and the fetch/decode register, so the dependent instruction is decoded again next cycle. It also tells the decode stage to write an all-zero control word into the decode/execute register. The load itself is not held back and moves on to the memory stage as usual. One cycle later the load has left execute, the condition clears, and the existing forwarding path supplies the loaded value.

The detector is purely combinational. A clock and a synchronous active-low reset are present only to time the embedded properties.

Top module: `luh_unit`

## Requirements
- R1: With `ex_is_load_i`=1, `ex_load_dst_i` nonzero and equal to `id_rs_i`, the block stalls: `bubble_o`=1, `pc_we_o`=0, `ifid_we_o`=0.
- R2: With `ex_is_load_i`=1, `ex_load_dst_i` nonzero and equal to `id_rt_i`, the block stalls in the same way.
- R3: With `ex_is_load_i`=0, no stall is raised whatever the register fields hold.
- R4: A load whose destination is register 0 never causes a stall, even if a decode source is also 0.
- R5: `pc_we_o` is 0 exactly in stall cycles and 1 in all other cycles.
- R6: `ifid_we_o` is 0 exactly in stall cycles and 1 in all other cycles.
- R7: `bubble_o` (1 = write zero control into decode/execute) is 1 only in stall cycles and only when a source match with a load exists.
- R8: In a pipeline where a stall freezes PC and fetch/decode and inserts a zero-control bubble while the load advances, one load-use pair gives exactly one stall cycle. The cycle after a stall never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to time the properties |
| rst_n | input | 1 | Synchronous active-low reset (property qualifier) |
| ex_is_load_i | input | 1 | Execute-stage instruction reads data memory |
| ex_load_dst_i | input | REG_AW | Destination register of the execute-stage instruction |
| id_rs_i | input | REG_AW | First source register field in decode |
| id_rt_i | input | REG_AW | Second source register field in decode |
| pc_we_o | output | 1 | Program counter update enable |
| ifid_we_o | output | 1 | Fetch/decode register update enable |
| bubble_o | output | 1 | Select all-zero control for the decode/execute register |

## Verification
Two things can happen in the same cycle: a match on the first source and a match on the second source, when the decode instruction names the loaded register in both fields. The bench forces this case directly. It also produces it often in closed-loop runs, where random instruction streams draw from only four registers. The expected result is still a single one-cycle stall. The next cycle is then checked for the absence of a stall, while the bubble sits in execute and the held instruction is decoded again.

// File: rtl/luh_pkg.sv
// Shared types for the load-use stall detector.
// Assumes the register index width is set by the parameter REG_AW of the top module.
package luh_pkg;
    // Front-end control produced by the stall detector
    typedef struct packed {
        logic pc_we;
        logic fetch_we;
        logic bubble;
    } front_ctl_t;

    // Default number of decode-stage source fields compared
    localparam int SRC_CNT_DEF = 2;
endpackage

// File: rtl/luh_src_match.sv
// Compares one producer register index against a set of consumer indices.
// Assumes index 0 is the hard-wired zero register, so it never matches.
module luh_src_match #(
    parameter int AW   = 5,
    parameter int NSRC = 2
) (
    input  logic                    valid_i,
    input  logic [AW-1:0]           dst_i,
    input  logic [NSRC-1:0][AW-1:0] src_i,
    output logic                    hit_o
);
    logic [NSRC-1:0] eq;
    logic            dst_live;

    // Per-source equality against the producer index
    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign eq[g] = (src_i[g] == dst_i);
    end

    // A producer index of zero carries no real value
    always_comb dst_live = |dst_i;

    // Any live match with a valid producer raises the hit
    always_comb hit_o = valid_i && dst_live && (|eq);
endmodule

// File: rtl/luh_stall_ctrl.sv
// Turns a hazard hit into the front-end enables and bubble select.
// Assumes a single stall cycle resolves the hazard.
module luh_stall_ctrl
    import luh_pkg::*;
(
    input  logic       hit_i,
    output front_ctl_t ctl_o
);
    // Freeze PC and fetch/decode, insert bubble, while a hit is present
    always_comb begin
        ctl_o.pc_we    = !hit_i;
        ctl_o.fetch_we = !hit_i;
        ctl_o.bubble   = hit_i;
    end
endmodule

// File: rtl/luh_unit.sv
// Load-use stall detector for an in-order five-stage pipeline.
// Assumes forwarding covers every other data dependence; clk and rst_n
// only time the embedded properties.
module luh_unit
    import luh_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ex_is_load_i,
    input  logic [REG_AW-1:0] ex_load_dst_i,
    input  logic [REG_AW-1:0] id_rs_i,
    input  logic [REG_AW-1:0] id_rt_i,
    output logic              pc_we_o,
    output logic              ifid_we_o,
    output logic              bubble_o
);
    localparam int NSRC = SRC_CNT_DEF;

    logic [NSRC-1:0][REG_AW-1:0] srcs;
    logic                        hit;
    front_ctl_t                  ctl;

    // Gather the decode source fields
    always_comb begin
        srcs[0] = id_rs_i;
        srcs[1] = id_rt_i;
    end

    luh_src_match #(.AW(REG_AW), .NSRC(NSRC)) u_match (
        .valid_i (ex_is_load_i),
        .dst_i   (ex_load_dst_i),
        .src_i   (srcs),
        .hit_o   (hit)
    );

    luh_stall_ctrl u_ctrl (
        .hit_i (hit),
        .ctl_o (ctl)
    );

    // Drive the ports from the controller
    always_comb begin
        pc_we_o   = ctl.pc_we;
        ifid_we_o = ctl.fetch_we;
        bubble_o  = ctl.bubble;
    end

    p_stall_rs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load_i && ex_load_dst_i != '0 && ex_load_dst_i == id_rs_i) |-> bubble_o);
    p_stall_rt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load_i && ex_load_dst_i != '0 && ex_load_dst_i == id_rt_i) |-> bubble_o);
    p_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load_i |-> (pc_we_o && ifid_we_o && !bubble_o));
    p_zero_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_load_dst_i == '0) |-> !bubble_o);
    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> !pc_we_o);
    p_ifid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> !ifid_we_o);
    p_bubble_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bubble_o |-> (ex_is_load_i && (ex_load_dst_i == id_rs_i || ex_load_dst_i == id_rt_i)));
    p_enables_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bubble_o |-> (pc_we_o && ifid_we_o));
endmodule

// File: tb/luh_unit_bench.sv
module luh_unit_bench;
    localparam int AW    = 5;
    localparam int PLEN  = 64;
    localparam int NCYC  = 3000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ex_ld;
    logic [AW-1:0] ex_dst, id_rs, id_rt;
    logic          pc_we, ifid_we, bubble;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    luh_unit #(.REG_AW(AW)) u_luh_unit (
        .clk(clk), .rst_n(rst_n),
        .ex_is_load_i(ex_ld), .ex_load_dst_i(ex_dst),
        .id_rs_i(id_rs), .id_rt_i(id_rt),
        .pc_we_o(pc_we), .ifid_we_o(ifid_we), .bubble_o(bubble)
    );

    function automatic bit f_stall(bit ld, logic [AW-1:0] d, logic [AW-1:0] s, logic [AW-1:0] t);
        return ld && (d != 0) && ((d == s) || (d == t));
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b (ld=%0b dst=%0d rs=%0d rt=%0d)",
                     tag, act, exp, ex_ld, ex_dst, id_rs, id_rt);
        end
    endtask

    task automatic chk_all(string tag, bit st);
        chk({tag, " bubble R7"}, bubble, st);
        chk({tag, " pc_we R5"}, pc_we, !st);
        chk({tag, " ifid_we R6"}, ifid_we, !st);
    endtask

    task automatic apply(bit ld, int d, int s, int t, string tag);
        @(negedge clk);
        ex_ld = ld; ex_dst = AW'(d); id_rs = AW'(s); id_rt = AW'(t);
        #1;
        chk_all(tag, f_stall(ld, AW'(d), AW'(s), AW'(t)));
    endtask

    // program image and pipeline model state
    bit            p_ld [PLEN];
    logic [AW-1:0] p_rd [PLEN];
    logic [AW-1:0] p_rs [PLEN];
    logic [AW-1:0] p_rt [PLEN];

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        int  pc;
        bit  fd_ld; logic [AW-1:0] fd_rd, fd_rs, fd_rt;
        bit  prev_st;
        int  stalls;
        void'($urandom(32'd2024));
        ex_ld = 0; ex_dst = 0; id_rs = 0; id_rt = 0;
        repeat (3) @(posedge clk);
        #1;
        chk_all("reset R3", 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // directed corners
        apply(1, 7, 7, 3, "R1 rs match");
        apply(1, 9, 2, 9, "R2 rt match");
        apply(1, 5, 5, 5, "R1 R2 both match");
        apply(0, 6, 6, 6, "R3 no load");
        apply(1, 0, 0, 0, "R4 zero dst");
        apply(1, 0, 0, 4, "R4 zero dst rs zero");
        apply(1, 31, 30, 29, "R7 no match");
        apply(1, 31, 31, 0, "R1 top index");

        // random open-loop patterns
        for (int i = 0; i < 300; i++)
            apply($urandom_range(1, 0), $urandom_range(7, 0),
                  $urandom_range(7, 0), $urandom_range(7, 0), "R1 R2 R3 random");

        // closed-loop pipeline model
        for (int i = 0; i < PLEN; i++) begin
            p_ld[i] = ($urandom_range(2, 0) == 0);
            p_rd[i] = AW'($urandom_range(3, 0));
            p_rs[i] = AW'($urandom_range(3, 0));
            p_rt[i] = AW'($urandom_range(3, 0));
        end
        p_ld[10] = 1; p_rd[10] = 2; p_rs[11] = 2; p_rt[11] = 2;
        pc = 0; fd_ld = 0; fd_rd = 0; fd_rs = 0; fd_rt = 0;
        ex_ld = 0; ex_dst = 0;
        prev_st = 0; stalls = 0;
        for (int c = 0; c < NCYC; c++) begin
            bit st;
            @(negedge clk);
            id_rs = fd_rs; id_rt = fd_rt;
            #1;
            st = f_stall(ex_ld, ex_dst, fd_rs, fd_rt);
            chk_all("loop", st);
            if (prev_st) chk("R8 no second stall", bubble, 1'b0);
            if (st) stalls++;
            prev_st = st;
            // state update at the edge
            @(posedge clk);
            if (st) begin
                ex_ld = 0; ex_dst = 0;
            end else begin
                ex_ld = fd_ld; ex_dst = fd_rd;
                fd_ld = p_ld[pc % PLEN]; fd_rd = p_rd[pc % PLEN];
                fd_rs = p_rs[pc % PLEN]; fd_rt = p_rt[pc % PLEN];
                pc++;
            end
        end
        chk("R8 progress", (pc + stalls == NCYC) ? 1'b1 : 1'b0, 1'b1);
        chk("R8 stalls seen", (stalls > 0) ? 1'b1 : 1'b0, 1'b1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule